// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This engine folds one 512-bit message block into a 160-bit chaining state using the eighty-step SHA-1 compression, one step per clock. The caller presents the block as sixteen big-endian 32-bit words packed into one wide bus, with word 0 in the top 32 bits. A start strobe, taken only while the engine is idle, launches the compression. When the last step has run, the five working words are added back into the chaining state and a one-cycle completion strobe is raised.

The chaining state is kept between blocks, so a padded multi-block message is hashed by issuing its blocks one after another. A separate init strobe loads the standard initial vector before a new message. Padding, memory access and byte-order conversion belong to the caller.

The message schedule is not stored in full. A sixteen-word shift window holds the words still needed, and each step produces the next expanded word from four fixed taps.

Top module: `sha1_core`

## Requirements
- R1: After reset, `digest_o` equals 67452301_efcdab89_98badcfe_10325476_c3d2e1f0, with H0 in bits [159:128], and both `busy_o` and `done_o` are low.
- R2: An init strobe taken while idle makes `digest_o` equal the initial vector of R1 on the next cycle.
- R3: A start strobe taken while idle and without init raises `busy_o` on the next cycle and captures `blk_data_i`, with schedule word 0 in bits [511:480] and word 15 in bits [31:0].
- R4: `done_o` is high for exactly one cycle. It rises on the 81st rising edge after the edge that took the start. `busy_o` falls on that same edge.
- R5: At completion, `digest_o` equals the SHA-1 compression of the captured block applied to the prior chaining state. For the padded one-block message "abc" this is a9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d, and for the padded pangram "The quick brown fox jumps over the lazy dog" it is 2fd4e1c6_7a2d28fc_ed849ee1_bb76e739_1b93eb12.
- R6: A block started with no init since the previous completion is compressed on top of the previous digest, so multi-block messages chain.
- R7: A start strobe raised while busy is ignored. The run in progress keeps its timing and result.
- R8: An init strobe raised while busy is ignored. The chaining state is unchanged until the fold.
- R9: When init and start come in the same idle cycle, init takes effect and start is ignored: `busy_o` stays low and no `done_o` follows.
- R10: `digest_o` holds its value on every cycle that has no accepted init and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Load the initial vector into the chaining state (idle only) |
| blk_start_i | input | 1 | Start compressing `blk_data_i` (idle only) |
| blk_data_i | input | 512 | Sixteen big-endian words, word 0 in the top bits |
| busy_o | output | 1 | High from the accepted start until the fold |
| done_o | output | 1 | One-cycle strobe when the chaining state has been updated |
| digest_o | output | 160 | Chaining state H0..H4, H0 in the top bits |

## Verification
The hardest conditions to reach from the ports are the strobes that arrive while a block is in flight, because they must leave both the step timing and the result untouched. The stimulus raises a conflicting start, carrying different random data, or an init partway through chosen runs. It then compares the digest with a bench model that never saw the intrusion. Long random chains of blocks without intervening init exercise the feed-forward across blocks, and two padded known-answer messages pin down the word order and the four step ranges.

// File: rtl/sha1_eng_pkg.sv
package sha1_eng_pkg;

    localparam int WORD_W        = 32;
    localparam int WIN_LEN       = 16;
    localparam int NUM_STEPS     = 80;
    localparam int STEPS_PER_RND = 20;
    localparam int NUM_CHAIN     = 5;
    localparam int BLK_W         = WORD_W * WIN_LEN;
    localparam int DIG_W         = WORD_W * NUM_CHAIN;
    localparam int CNT_W         = $clog2(NUM_STEPS);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } chain_t;

    typedef enum logic [1:0] {
        RND_CHOOSE,
        RND_PARITY_LO,
        RND_MAJORITY,
        RND_PARITY_HI
    } rnd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_FOLD
    } phase_e;

    localparam chain_t CHAIN_IV = '{
        a: 32'h67452301,
        b: 32'hefcdab89,
        c: 32'h98badcfe,
        d: 32'h10325476,
        e: 32'hc3d2e1f0
    };

    function automatic word_t rotl1(word_t v);
        return {v[WORD_W-2:0], v[WORD_W-1]};
    endfunction

    function automatic word_t rotl5(word_t v);
        return {v[WORD_W-6:0], v[WORD_W-1:WORD_W-5]};
    endfunction

    function automatic word_t rotl30(word_t v);
        return {v[1:0], v[WORD_W-1:2]};
    endfunction

    function automatic rnd_e rnd_of(int step);
        if (step < STEPS_PER_RND)          return RND_CHOOSE;
        else if (step < 2 * STEPS_PER_RND) return RND_PARITY_LO;
        else if (step < 3 * STEPS_PER_RND) return RND_MAJORITY;
        else                               return RND_PARITY_HI;
    endfunction

    function automatic word_t k_of(rnd_e r);
        case (r)
            RND_CHOOSE:    return 32'h5a827999;
            RND_PARITY_LO: return 32'h6ed9eba1;
            RND_MAJORITY:  return 32'h8f1bbcdc;
            default:       return 32'hca62c1d6;
        endcase
    endfunction

    function automatic word_t f_of(rnd_e r, word_t x, word_t y, word_t z);
        case (r)
            RND_CHOOSE:   return (x & y) | (~x & z);
            RND_MAJORITY: return (x & y) | (x & z) | (y & z);
            default:      return x ^ y ^ z;
        endcase
    endfunction

    function automatic chain_t chain_add(chain_t p, chain_t q);
        chain_t s;
        s.a = p.a + q.a;
        s.b = p.b + q.b;
        s.c = p.c + q.c;
        s.d = p.d + q.d;
        s.e = p.e + q.e;
        return s;
    endfunction

endpackage

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
    import sha1_eng_pkg::*;
#(
    parameter int STEPS = NUM_STEPS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         init_i,
    input  logic                         blk_start_i,
    output logic                         load_o,
    output logic                         run_o,
    output logic                         fold_o,
    output logic                         init_acc_o,
    output logic [$clog2(STEPS)-1:0]     step_o,
    output logic                         busy_o,
    output logic                         done_o
);

    localparam int SW = $clog2(STEPS);
    localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

    phase_e          phase_q;
    logic [SW-1:0]   step_q;
    logic            done_q;

    assign init_acc_o = (phase_q == PH_IDLE) && init_i;
    assign load_o     = (phase_q == PH_IDLE) && blk_start_i && !init_i;
    assign run_o      = (phase_q == PH_RUN);
    assign fold_o     = (phase_q == PH_FOLD);
    assign step_o     = step_q;
    assign busy_o     = (phase_q != PH_IDLE);
    assign done_o     = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_FOLD);
            case (phase_q)
                PH_IDLE: begin
                    if (load_o) begin
                        phase_q <= PH_RUN;
                        step_q  <= '0;
                    end
                end
                PH_RUN: begin
                    if (step_q == LAST_STEP) begin
                        phase_q <= PH_FOLD;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);                                           // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (phase_q == PH_IDLE));                              // R4
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (step_q <= LAST_STEP));                              // R5
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (run_o && blk_start_i && step_q != LAST_STEP)
            |=> (run_o && step_q == SW'($past(step_q) + 1'b1)));       // R7

endmodule

// File: rtl/sha1_sched.sv
module sha1_sched
    import sha1_eng_pkg::*;
#(
    parameter int DEPTH = WIN_LEN
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    shift_i,
    input  logic [DEPTH*WORD_W-1:0] blk_i,
    output word_t                   w_o
);

    localparam int TAP_A = DEPTH - 3;
    localparam int TAP_B = DEPTH - 8;
    localparam int TAP_C = DEPTH - 14;
    localparam int TAP_D = 0;

    word_t win_q   [DEPTH];
    word_t blk_w   [DEPTH];
    word_t next_w;

    for (genvar g = 0; g < DEPTH; g++) begin : g_split
        assign blk_w[g] = blk_i[(DEPTH-g)*WORD_W-1 -: WORD_W];
    end

    assign next_w = rotl1(win_q[TAP_A] ^ win_q[TAP_B] ^ win_q[TAP_C] ^ win_q[TAP_D]);
    assign w_o    = win_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) win_q[i] <= '0;
        end else if (load_i) begin
            for (int i = 0; i < DEPTH; i++) win_q[i] <= blk_w[i];
        end else if (shift_i) begin
            for (int i = 0; i < DEPTH - 1; i++) win_q[i] <= win_q[i+1];
            win_q[DEPTH-1] <= next_w;
        end
    end

    AST_WIN_FIRST: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (w_o == $past(blk_i[DEPTH*WORD_W-1 -: WORD_W])));  // R3

endmodule

// File: rtl/sha1_round.sv
module sha1_round
    import sha1_eng_pkg::*;
#(
    parameter int STEPS = NUM_STEPS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic                     run_i,
    input  logic [$clog2(STEPS)-1:0] step_i,
    input  word_t                    w_i,
    input  chain_t                   h_i,
    output chain_t                   work_o
);

    chain_t work_q;
    rnd_e   rnd;
    word_t  t_val;

    assign rnd    = rnd_of(int'(step_i));
    assign t_val  = rotl5(work_q.a) + f_of(rnd, work_q.b, work_q.c, work_q.d)
                  + w_i + k_of(rnd) + work_q.e;
    assign work_o = work_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
        end else if (load_i) begin
            work_q <= h_i;
        end else if (run_i) begin
            work_q.a <= t_val;
            work_q.b <= work_q.a;
            work_q.c <= rotl30(work_q.b);
            work_q.d <= work_q.c;
            work_q.e <= work_q.d;
        end
    end

    AST_WORK_SHIFT: assert property (@(posedge clk) disable iff (rst)
        run_i |=> (work_o.e == $past(work_o.d) && work_o.b == $past(work_o.a))); // R5

endmodule

// File: rtl/sha1_chain.sv
module sha1_chain
    import sha1_eng_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   init_i,
    input  logic   fold_i,
    input  chain_t work_i,
    output chain_t h_o
);

    chain_t h_q;

    assign h_o = h_q;

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            h_q <= CHAIN_IV;
        end else if (fold_i) begin
            h_q <= chain_add(h_q, work_i);
        end
    end

    AST_INIT_IV: assert property (@(posedge clk) disable iff (rst)
        $past(init_i) |-> (h_q == CHAIN_IV));                          // R2
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(init_i) && !$past(fold_i) && !$past(rst)) |-> $stable(h_q)); // R10

endmodule

// File: rtl/sha1_core.sv
module sha1_core
    import sha1_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_i,
    input  logic             blk_start_i,
    input  logic [BLK_W-1:0] blk_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DIG_W-1:0] digest_o
);

    logic             load;
    logic             run;
    logic             fold;
    logic             init_acc;
    logic [CNT_W-1:0] step;
    word_t            w_cur;
    chain_t           work;
    chain_t           h_state;

    sha1_ctrl #(.STEPS(NUM_STEPS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .init_i      (init_i),
        .blk_start_i (blk_start_i),
        .load_o      (load),
        .run_o       (run),
        .fold_o      (fold),
        .init_acc_o  (init_acc),
        .step_o      (step),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    sha1_sched #(.DEPTH(WIN_LEN)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .shift_i (run),
        .blk_i   (blk_data_i),
        .w_o     (w_cur)
    );

    sha1_round #(.STEPS(NUM_STEPS)) u_round (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .run_i  (run),
        .step_i (step),
        .w_i    (w_cur),
        .h_i    (h_state),
        .work_o (work)
    );

    sha1_chain u_chain (
        .clk    (clk),
        .rst    (rst),
        .init_i (init_acc),
        .fold_i (fold),
        .work_i (work),
        .h_o    (h_state)
    );

    assign digest_o = h_state;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && blk_start_i && !init_i) |=> busy_o);               // R3
    AST_INIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && blk_start_i && init_i) |=> !busy_o);               // R9
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);                                     // R4

endmodule

// File: tb/test_sha1_core.sv
`timescale 1ns/1ps
module test_sha1_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         init_i = 1'b0;
    logic         blk_start_i = 1'b0;
    logic [511:0] blk_data_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [159:0] digest_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [159:0] model_h;

    localparam logic [159:0] IV_VAL  = 160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;
    localparam logic [159:0] ABC_DIG = 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d;
    localparam logic [159:0] FOX_DIG = 160'h2fd4e1c6_7a2d28fc_ed849ee1_bb76e739_1b93eb12;

    always #2 clk = ~clk;

    sha1_core i_sha1_core (
        .clk         (clk),
        .rst         (rst),
        .init_i      (init_i),
        .blk_start_i (blk_start_i),
        .blk_data_i  (blk_data_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .digest_o    (digest_o)
    );

    function automatic logic [31:0] rl(logic [31:0] v, int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    function automatic logic [159:0] ref_compress(logic [159:0] h, logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, tt;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5a827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ed9eba1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
            else             begin f = b ^ c ^ d;                   k = 32'hca62c1d6; end
            tt = rl(a, 5) + f + w[i] + k + e;
            e = d; d = c; c = rl(b, 30); b = a; a = tt;
        end
        return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    function automatic logic [511:0] pad_one(string s);
        logic [511:0] r = '0;
        int n = s.len();
        for (int i = 0; i < n; i++) r[511-8*i -: 8] = s[i];
        r[511-8*n -: 8] = 8'h80;
        r[63:0] = 64'(n * 8);
        return r;
    endfunction

    function automatic logic [511:0] rand_blk();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_init();
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); init_i = 1'b0;
        model_h = IV_VAL;
    endtask

    // mode 0: clean run, 1: stray start mid-run, 2: stray init mid-run
    task automatic run_block(logic [511:0] blk, int mode);
        int cnt;
        @(negedge clk); blk_data_i = blk; blk_start_i = 1'b1;
        @(negedge clk); blk_start_i = 1'b0;
        chk("R3 busy after start", 160'(busy_o), 160'(1));
        cnt = 0;
        while (!done_o && cnt < 300) begin
            if (cnt == 30 && mode == 1) begin blk_start_i = 1'b1; blk_data_i = rand_blk(); end
            if (cnt == 30 && mode == 2) init_i = 1'b1;
            if (cnt == 31) begin blk_start_i = 1'b0; init_i = 1'b0; end
            @(negedge clk);
            cnt++;
        end
        chk("R4 done latency", 160'(cnt), 160'(81));
        chk("R4 busy low at done", 160'(busy_o), 160'(0));
        model_h = ref_compress(model_h, blk);
        if (mode == 1)      chk("R7 start while busy ignored", digest_o, model_h);
        else if (mode == 2) chk("R8 init while busy ignored", digest_o, model_h);
        else                chk("R5/R6 digest", digest_o, model_h);
        @(negedge clk);
        chk("R4 done single cycle", 160'(done_o), 160'(0));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [159:0] held;
        void'($urandom(32'h1F2E3D4C));
        model_h = IV_VAL;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset digest", digest_o, IV_VAL);
        chk("R1 reset busy", 160'(busy_o), 160'(0));
        chk("R1 reset done", 160'(done_o), 160'(0));

        // known answers, single padded block each
        run_block(pad_one("abc"), 0);
        chk("R5 abc vector", digest_o, ABC_DIG);

        held = digest_o;
        repeat (6) @(negedge clk);
        chk("R10 digest holds while idle", digest_o, held);

        pulse_init();
        chk("R2 init reloads IV", digest_o, IV_VAL);

        run_block(pad_one("The quick brown fox jumps over the lazy dog"), 0);
        chk("R5 pangram vector", digest_o, FOX_DIG);

        // random chains of blocks, some with intrusions while busy
        for (int ch = 0; ch < 8; ch++) begin
            int nb;
            pulse_init();
            nb = 1 + int'($urandom_range(2));
            for (int bi = 0; bi < nb; bi++) begin
                run_block(rand_blk(), int'($urandom_range(2)));
            end
            chk("R6 chained digest", digest_o, model_h);
        end

        // R9: init and start together while idle
        @(negedge clk); init_i = 1'b1; blk_start_i = 1'b1; blk_data_i = rand_blk();
        @(negedge clk); init_i = 1'b0; blk_start_i = 1'b0;
        model_h = IV_VAL;
        chk("R9 init wins over start", digest_o, IV_VAL);
        chk("R9 no busy", 160'(busy_o), 160'(0));
        begin
            int seen = 0;
            repeat (100) begin
                @(negedge clk);
                if (done_o) seen++;
            end
            chk("R9 no done follows", 160'(seen), 160'(0));
        end
        chk("R10 digest unchanged after ignored start", digest_o, IV_VAL);

        finish_run();
    end

endmodule